// File: doc/BRIEF.md
# Performance report message transmit scheduler

This block decides when a one-second performance report message goes out on the facility data link, and which control bit values it carries. Software supplies five bit values in register fields: command/response, R, U1, U2 and slip. It also sets an automatic-slip-insertion enable, an auto-send enable and a self-clearing send-now command. A one-second tick and a receive frame-slip event also come in as inputs.

When a send starts, the block takes a snapshot of the bit values and raises a request to the downstream message formatter. The request stays high until the formatter returns a one-cycle done pulse. HDLC framing, CRC and serialization all belong to the formatter.

Sends come from two sources: the one-second tick while auto-send is enabled, and the software send-now command. The block arbitrates between them. If software asks for a send while one is already in flight, a single request is held pending and issued once the current send completes.

The slip bit in the message comes from one of two places. With automatic slip insertion off, it is the software value. With it on, it is a sticky frame-slip flag that the block keeps itself.

Top module: `prm_tx_sched`

## Requirements
- R1: During and after reset, with no trigger, `req_o` is 0 and `msg_o` is all zeros.
- R2: The snapshot `msg_o` is {cr, r, u1, u2, sl} from bit 4 down to bit 0. The first four bits are the input values in the cycle the send starts, and they are visible the cycle after, together with `req_o` rising.
- R3: With `auto_sl_i` = 0 at the start cycle, `msg_o[0]` is the `sl_i` value from that cycle.
- R4: With `auto_sl_i` = 1 at the start cycle, `msg_o[0]` is a sticky slip flag. A `slip_i` pulse sets the flag. A start with `auto_sl_i` = 1 clears it. A slip in the start cycle itself is kept for the next message.
- R5: While idle, a `tick_i` pulse with `auto_en_i` = 1 raises `req_o` on the next cycle. A tick with `auto_en_i` = 0 has no effect.
- R6: While idle, a `send_now_i` pulse raises `req_o` on the next cycle, whatever the value of `auto_en_i`.
- R7: A tick and a send-now command in the same idle cycle produce a single message.
- R8: A `send_now_i` pulse while `req_o` is high is held pending. After `done_i`, `req_o` stays low for exactly one cycle and then rises again. Any further commands during the same busy period are merged into that one pending request.
- R9: `req_o` stays high, and `msg_o` holds its value, until a `done_i` pulse. `req_o` then falls on the next cycle. A `done_i` pulse while idle has no effect.
- R10: A one-second tick that arrives while `req_o` is high is dropped and is never served later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cr_i | input | 1 | Software command/response bit |
| r_i | input | 1 | Software R bit |
| u1_i | input | 1 | Software U1 bit |
| u2_i | input | 1 | Software U2 bit |
| sl_i | input | 1 | Software slip bit |
| auto_sl_i | input | 1 | 1: slip bit taken from the sticky slip flag |
| slip_i | input | 1 | Receive frame-slip event pulse |
| tick_i | input | 1 | One-second timing pulse |
| auto_en_i | input | 1 | Enables sends on the one-second tick |
| send_now_i | input | 1 | Immediate-send command pulse |
| done_i | input | 1 | Formatter acknowledge, one cycle |
| req_o | output | 1 | Send request to the formatter |
| msg_o | output | 5 | Snapshot {cr, r, u1, u2, sl} |

## Verification
The assertions check on every cycle the parts of the handshake that stand alone:
- the request holds until done and drops after it;
- the snapshot stays stable while the request is high;
- each kind of idle trigger raises the request one cycle later;
- with no trigger, the request stays low;
- the software-sourced bits land in the snapshot.

Other behaviour depends on history across several messages, so only the bench scenarios can show it:
- the sticky slip flag being cleared by one message and carried into the next;
- the single pending command and the merging of extra ones;
- ticks dropped while a send is in flight;
- the merge when a tick and a command arrive in the same cycle.

// File: rtl/prm_sched_pkg.sv
package prm_sched_pkg;
  typedef struct packed {
    logic cr;
    logic r;
    logic u1;
    logic u2;
    logic sl;
  } prm_bits_t;

  localparam int unsigned PRM_W = $bits(prm_bits_t);
endpackage

// File: rtl/prm_slip_sticky.sv
module prm_slip_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slip_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // a slip in the clearing cycle survives for the next message
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= slip_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/prm_trig_arb.sv
module prm_trig_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic auto_en_i,
  input  logic now_i,
  input  logic done_i,
  output logic launch_o,
  output logic busy_o,
  output logic pend_o
);
  logic busy_q, pend_q;
  logic auto_trig, launch;

  assign auto_trig = tick_i & auto_en_i;
  // launch only from idle; a pending command waits one idle cycle
  assign launch    = ~busy_q & (now_i | auto_trig | pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
    end else if (launch) begin
      busy_q <= 1'b1;
    end else if (busy_q && done_i) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (launch) begin
      pend_q <= 1'b0;
    end else if (busy_q && now_i) begin
      pend_q <= 1'b1;
    end
  end

  assign launch_o = launch;
  assign busy_o   = busy_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/prm_snap.sv
module prm_snap
  import prm_sched_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  prm_bits_t bits_i,
  output prm_bits_t snap_o
);
  prm_bits_t snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= '0;
    else if (load_i) snap_q <= bits_i;
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/prm_tx_sched.sv
module prm_tx_sched
  import prm_sched_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cr_i,
  input  logic             r_i,
  input  logic             u1_i,
  input  logic             u2_i,
  input  logic             sl_i,
  input  logic             auto_sl_i,
  input  logic             slip_i,
  input  logic             tick_i,
  input  logic             auto_en_i,
  input  logic             send_now_i,
  input  logic             done_i,
  output logic             req_o,
  output logic [PRM_W-1:0] msg_o
);
  logic      launch_w, busy_w, pend_w, slip_flag_w;
  prm_bits_t cur_bits, snap_bits;

  prm_trig_arb u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .auto_en_i (auto_en_i),
    .now_i     (send_now_i),
    .done_i    (done_i),
    .launch_o  (launch_w),
    .busy_o    (busy_w),
    .pend_o    (pend_w)
  );

  prm_slip_sticky u_slip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slip_i (slip_i),
    .clr_i  (launch_w & auto_sl_i),
    .flag_o (slip_flag_w)
  );

  always_comb begin
    cur_bits.cr = cr_i;
    cur_bits.r  = r_i;
    cur_bits.u1 = u1_i;
    cur_bits.u2 = u2_i;
    cur_bits.sl = auto_sl_i ? slip_flag_w : sl_i;
  end

  prm_snap u_snap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (launch_w),
    .bits_i (cur_bits),
    .snap_o (snap_bits)
  );

  assign req_o = busy_w;
  assign msg_o = snap_bits;
endmodule

// File: rtl/prm_tx_sched_chk.sv
module prm_tx_sched_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       done_i,
  input logic [4:0] msg_i,
  input logic [3:0] hi_bits_i,
  input logic       sl_i,
  input logic       auto_sl_i,
  input logic       tick_i,
  input logic       auto_en_i,
  input logic       now_i,
  input logic       pend_i
);
  assert_hold_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !done_i |=> req_i);

  assert_drop_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && done_i |=> !req_i);

  assert_msg_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !done_i |=> $stable(msg_i));

  assert_now_launch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i && now_i |=> req_i);

  assert_tick_launch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i && tick_i && auto_en_i |=> req_i);

  assert_no_spurious_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i && !now_i && !(tick_i && auto_en_i) && !pend_i |=> !req_i);

  assert_pend_serve_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i && pend_i |=> req_i);

  assert_hi_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i) |-> msg_i[4:1] == $past(hi_bits_i));

  assert_sw_sl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i) && !$past(auto_sl_i) |-> msg_i[0] == $past(sl_i));
endmodule

bind prm_tx_sched prm_tx_sched_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_o),
  .done_i    (done_i),
  .msg_i     (msg_o),
  .hi_bits_i ({cr_i, r_i, u1_i, u2_i}),
  .sl_i      (sl_i),
  .auto_sl_i (auto_sl_i),
  .tick_i    (tick_i),
  .auto_en_i (auto_en_i),
  .now_i     (send_now_i),
  .pend_i    (pend_w)
);

// File: tb/test_prm_tx_sched.sv
module test_prm_tx_sched;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cr, r, u1, u2, sl, auto_sl, slip, tick, auto_en, now, done;
  logic req;
  logic [4:0] msg;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  prm_tx_sched i_prm_tx_sched (
    .clk_i(clk), .rst_ni(rst_ni), .cr_i(cr), .r_i(r), .u1_i(u1), .u2_i(u2),
    .sl_i(sl), .auto_sl_i(auto_sl), .slip_i(slip), .tick_i(tick),
    .auto_en_i(auto_en), .send_now_i(now), .done_i(done),
    .req_o(req), .msg_o(msg)
  );

  // reference model built from the requirements
  logic m_busy, m_pend, m_slip;
  logic [4:0] m_msg;

  function automatic logic f_start(input logic busy, pend, n, t, ae);
    return !busy && (n || (t && ae) || pend);
  endfunction

  function automatic logic [4:0] f_msg(input logic c, rr, a, b, s, asl, flag);
    return {c, rr, a, b, asl ? flag : s};
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy <= 1'b0; m_pend <= 1'b0; m_slip <= 1'b0; m_msg <= '0;
    end else begin
      if (f_start(m_busy, m_pend, now, tick, auto_en)) begin
        m_msg  <= f_msg(cr, r, u1, u2, sl, auto_sl, m_slip);
        m_busy <= 1'b1;
        m_pend <= 1'b0;
      end else begin
        if (m_busy && done) m_busy <= 1'b0;
        if (m_busy && now)  m_pend <= 1'b1;
      end
      m_slip <= slip | (m_slip & ~(f_start(m_busy, m_pend, now, tick, auto_en) & auto_sl));
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_pulses();
    slip = 0; tick = 0; now = 0; done = 0;
  endtask

  // one clock edge, then sample at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    clr_pulses();
  endtask

  task automatic set_bits(input logic [4:0] b);
    {cr, r, u1, u2, sl} = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_bits(5'b0); auto_sl = 0; auto_en = 0; clr_pulses();
    repeat (3) @(negedge clk);
    chk("R1 req in reset", req, 0);
    chk("R1 msg in reset", msg, 0);
    rst_ni = 1;
    step();
    chk("R1 req after reset", req, 0);
    chk("R1 msg after reset", msg, 0);

    // R6 + R2 + R3
    set_bits(5'b10111); now = 1;
    step();
    chk("R6 req on send-now", req, 1);
    chk("R2 R3 snapshot", msg, 5'b10111);
    set_bits(5'b01000);
    step(); step();
    chk("R9 req held", req, 1);
    chk("R9 msg held", msg, 5'b10111);
    done = 1;
    step();
    chk("R9 req drops on done", req, 0);
    done = 1;
    step();
    chk("R9 done while idle ignored", req, 0);

    // R5
    tick = 1; auto_en = 0;
    step();
    chk("R5 tick without auto ignored", req, 0);
    auto_en = 1; tick = 1; set_bits(5'b01010);
    step();
    chk("R5 tick with auto", req, 1);
    chk("R2 tick snapshot", msg, 5'b01010);
    done = 1; step();

    // R7
    tick = 1; now = 1;
    step();
    chk("R7 merged req", req, 1);
    done = 1; step();
    chk("R7 after done", req, 0);
    step();
    chk("R7 single message", req, 0);

    // R8 + R10
    now = 1; step();
    now = 1; step();
    now = 1; tick = 1; step();
    step();
    done = 1; step();
    chk("R8 gap cycle", req, 0);
    step();
    chk("R8 pending issued", req, 1);
    done = 1; step();
    step(); step();
    chk("R8 R10 only one pending, tick dropped", req, 0);

    // R4
    auto_en = 0; auto_sl = 1; set_bits(5'b00000);
    slip = 1; step();
    now = 1; step();
    chk("R4 sticky slip in SL", msg[0], 1);
    done = 1; step();
    now = 1; step();
    chk("R4 flag cleared after capture", msg[0], 0);
    done = 1; step();
    now = 1; slip = 1; step();
    chk("R4 slip in capture cycle not sent", msg[0], 0);
    done = 1; step();
    now = 1; step();
    chk("R4 slip in capture cycle kept", msg[0], 1);
    done = 1; step();

    // R3 with a pending slip flag
    slip = 1; step();
    auto_sl = 0; sl = 0; now = 1; step();
    chk("R3 software SL overrides flag", msg[0], 0);
    done = 1; step();
    auto_sl = 1; now = 1; step();
    chk("R4 flag kept when not captured", msg[0], 1);
    done = 1; step();

    // randomized, against the model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      set_bits(5'($urandom));
      if ($urandom_range(0, 31) == 0) auto_sl = ~auto_sl;
      if ($urandom_range(0, 63) == 0) auto_en = ~auto_en;
      slip = ($urandom_range(0, 9) == 0);
      tick = ($urandom_range(0, 7) == 0);
      now  = ($urandom_range(0, 11) == 0);
      done = req ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 15) == 0);
      @(posedge clk);
      @(negedge clk);
      chk("R9 R8 random req", req, m_busy);
      if (m_busy) chk("R2 R4 random msg", msg, m_msg);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule